// File: doc/BRIEF.md
# Overload Timer and Hiccup Sequencer

This block manages faults for a peak-current-mode switching controller. Every switching cycle, the current comparator tells the block whether the maximum peak-current limit was hit. The block raises an error flag on such a hit. While that flag stays set, it counts elapsed time on a 1 MHz tick that it derives from the system clock. The flag and its timer clear as soon as one complete switching cycle ends without a limit hit, so only a sustained overload builds up time.

When the overload time reaches its limit, the gate drive is withdrawn. The next step depends on the latched-mode select:

- **Auto-recovery:** the block waits for the supply to discharge to the wake level. It then waits for the start threshold and restarts. This gives a repeating hiccup while the fault persists.
- **Latched:** the block stays off until the supply drops below its reset level.

Every start, first or retried, goes through a linear soft-start. During soft-start the current setpoint code is the lower of a rising ramp and the loop's own demand.

Top module: `overload_hiccup_ctrl`

## Requirements
- R1: After reset, `state` is 0 (idle), `drv_en` is 0 and `setpoint` is 0.
- R2: In idle (state 0), the block moves to soft-start (state 1) on the clock after `start_ok` is high. While `start_ok` is low, it stays in idle.
- R3: In soft-start (state 1):
  - `drv_en` is 1.
  - `setpoint` equals min(floor(k*(2^SP_W-1)/SOFT_TICKS), `demand`), where k is the number of ticks elapsed in the state.
  - `setpoint` never decreases while `demand` is constant.
  - After SOFT_TICKS ticks, the state becomes run (state 2).
- R4: In run (state 2), `drv_en` is 1 and `setpoint` equals `demand` in the same cycle.
- R5: While drive is enabled, a `lim_hit` pulse sets an error flag. When the flag has stayed set for FAULT_TICKS ticks, drive stops (`drv_en` goes 0).
- R6: A switching cycle that closes with a `cyc_end` pulse, and that had no `lim_hit` since the previous `cyc_end`, clears the error flag and its timer.
- R7: A timeout with `latch_mode` low leads to discharge (state 3), with `drv_en` 0 and `setpoint` 0. In discharge, `start_ok` has no effect until `wake_ok` is seen.
- R8: In discharge, `wake_ok` returns the block to idle, and from idle it restarts through soft-start. A fault that is still present times out again. A cleared fault lets the block reach run.
- R9: A timeout with `latch_mode` high leads to latched-off (state 4). In that state, `wake_ok` and `start_ok` have no effect.
- R10: `uvlo` high moves any state to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_hit | input | 1 | One-clock pulse: peak-current limit reached in this switching cycle |
| cyc_end | input | 1 | One-clock pulse marking the end of a switching cycle |
| start_ok | input | 1 | Supply is at or above the start threshold |
| wake_ok | input | 1 | Supply has fallen to the wake level |
| uvlo | input | 1 | Supply is below the reset level |
| latch_mode | input | 1 | 1 selects latched shutdown on timeout, 0 selects auto-recovery |
| demand | input | SP_W | Setpoint requested by the regulation loop |
| drv_en | output | 1 | Gate drive enable |
| setpoint | output | SP_W | Peak-current setpoint code |
| state | output | 3 | 0 idle, 1 soft-start, 2 run, 3 discharge, 4 latched-off |

## Verification
The hardest situation to create is an overload that repeats for far longer than the timeout, yet is broken often enough that it must never trip. The bench reaches it with limit pulses in five of every six switching cycles, and holds that pattern for many timeout lengths while checking that drive stays on. The second hard situation is a fault that persists through a hiccup restart. For that, the bench keeps pulsing the limit while it releases the block from discharge. It then checks that the block passes through soft-start and times out again within one timeout window of the restart.

// File: rtl/ohs_pkg.sv
package ohs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RUN   = 3'd2,
    ST_DISCH = 3'd3,
    ST_LATCH = 3'd4
  } ohs_state_e;
endpackage

// File: rtl/ohs_tick_gen.sv
module ohs_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(DIV);
      logic [DW-1:0] cnt_q, cnt_d;
      logic          wrap;

      assign wrap = (cnt_q == DW'(DIV - 1));

      always_comb begin
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = wrap;

      assert_div_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/ohs_fault_timer.sv
module ohs_fault_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic lim_hit,
  input  logic cyc_end,
  output logic err,
  output logic timeout
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          seen_q, seen_d;
  logic          at_end;

  assign at_end = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    err_d  = 1'b0;
    seen_d = 1'b0;
    cnt_d  = '0;
    if (en) begin
      err_d = err_q;
      if (lim_hit)                 err_d = 1'b1;
      else if (cyc_end && !seen_q) err_d = 1'b0;
      seen_d = cyc_end ? 1'b0 : (seen_q | lim_hit);
      if (!err_d)                          cnt_d = '0;
      else if (err_q && tick && !at_end)   cnt_d = cnt_q + 1'b1;
      else                                 cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      err_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      err_q  <= err_d;
      seen_q <= seen_d;
    end
  end

  assign err     = err_q;
  assign timeout = en & err_q & tick & at_end;

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LIMIT));

  assert_clean_cycle_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cyc_end && !seen_q && !lim_hit) |=> (cnt_q == '0 && !err_q));

  assert_hit_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lim_hit) |=> err_q);
endmodule

// File: rtl/ohs_softstart_ramp.sv
module ohs_softstart_ramp #(
  parameter int STEPS = 4000,
  parameter int SP_W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            tick,
  input  logic [SP_W-1:0] demand,
  output logic [SP_W-1:0] sp_code,
  output logic            done
);
  localparam int CW   = $clog2(STEPS + 1);
  localparam int PW   = CW + SP_W;
  localparam int FULL = (1 << SP_W) - 1;

  logic [CW-1:0]   cnt_q, cnt_d;
  logic [PW-1:0]   prod, quot;
  logic [SP_W-1:0] ramp;

  always_comb begin
    cnt_d = '0;
    if (active) begin
      if (tick && cnt_q != CW'(STEPS)) cnt_d = cnt_q + 1'b1;
      else                             cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    prod    = PW'(cnt_q) * PW'(FULL);
    quot    = prod / PW'(STEPS);
    ramp    = quot[SP_W-1:0];
    sp_code = (ramp < demand) ? ramp : demand;
  end

  assign done = active && (cnt_q == CW'(STEPS));

  assert_ramp_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> (ramp >= $past(ramp)));
endmodule

// File: rtl/ohs_hiccup_fsm.sv
module ohs_hiccup_fsm
  import ohs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_ok,
  input  logic       wake_ok,
  input  logic       uvlo,
  input  logic       latch_mode,
  input  logic       ss_done,
  input  logic       timeout,
  output ohs_state_e st
);
  ohs_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (uvlo) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  if (start_ok) st_d = ST_SOFT;
        ST_SOFT: begin
          if (timeout)      st_d = latch_mode ? ST_LATCH : ST_DISCH;
          else if (ss_done) st_d = ST_RUN;
        end
        ST_RUN:   if (timeout) st_d = latch_mode ? ST_LATCH : ST_DISCH;
        ST_DISCH: if (wake_ok) st_d = ST_IDLE;
        ST_LATCH: st_d = ST_LATCH;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st = st_q;

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LATCH && !uvlo) |=> (st_q == ST_LATCH));

  assert_disch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DISCH && !wake_ok && !uvlo) |=> (st_q == ST_DISCH));

  assert_uvlo_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (st_q == ST_IDLE));

  assert_timeout_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !uvlo) |=> (st_q == ST_DISCH || st_q == ST_LATCH));
endmodule

// File: rtl/overload_hiccup_ctrl.sv
module overload_hiccup_ctrl
  import ohs_pkg::*;
#(
  parameter int CLK_PER_TICK = 50,
  parameter int FAULT_TICKS  = 100000,
  parameter int SOFT_TICKS   = 4000,
  parameter int SP_W         = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lim_hit,
  input  logic            cyc_end,
  input  logic            start_ok,
  input  logic            wake_ok,
  input  logic            uvlo,
  input  logic            latch_mode,
  input  logic [SP_W-1:0] demand,
  output logic            drv_en,
  output logic [SP_W-1:0] setpoint,
  output logic [2:0]      state
);
  ohs_state_e      st;
  logic            tick;
  logic            in_soft, in_run;
  logic            err_flag, timeout, ss_done;
  logic [SP_W-1:0] ramp_sp;

  assign in_soft = (st == ST_SOFT);
  assign in_run  = (st == ST_RUN);

  ohs_tick_gen #(.DIV(CLK_PER_TICK)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  ohs_fault_timer #(.LIMIT(FAULT_TICKS)) u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (in_soft | in_run),
    .tick    (tick),
    .lim_hit (lim_hit),
    .cyc_end (cyc_end),
    .err     (err_flag),
    .timeout (timeout)
  );

  ohs_softstart_ramp #(.STEPS(SOFT_TICKS), .SP_W(SP_W)) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (in_soft),
    .tick    (tick),
    .demand  (demand),
    .sp_code (ramp_sp),
    .done    (ss_done)
  );

  ohs_hiccup_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ok   (start_ok),
    .wake_ok    (wake_ok),
    .uvlo       (uvlo),
    .latch_mode (latch_mode),
    .ss_done    (ss_done),
    .timeout    (timeout),
    .st         (st)
  );

  always_comb begin
    drv_en   = in_soft | in_run;
    setpoint = '0;
    if (in_soft)     setpoint = ramp_sp;
    else if (in_run) setpoint = demand;
  end

  assign state = st;

  assert_soft_clip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_soft |-> (setpoint <= demand));

  assert_flag_only_driving_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_soft && !in_run) |=> !timeout);

  assert_err_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st == ST_IDLE)) |-> !err_flag);
endmodule

// File: tb/overload_hiccup_ctrl_test.sv
module overload_hiccup_ctrl_test;
  localparam int P  = 2;
  localparam int FT = 20;
  localparam int ST = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, lim_hit, cyc_end, start_ok, wake_ok, uvlo, latch_mode;
  logic [7:0] demand, setpoint;
  logic drv_en;
  logic [2:0] state;
  bit lim_en;
  int skip_mod;
  int total = 0;
  int bad = 0;

  overload_hiccup_ctrl #(.CLK_PER_TICK(P), .FAULT_TICKS(FT), .SOFT_TICKS(ST), .SP_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .lim_hit(lim_hit), .cyc_end(cyc_end),
    .start_ok(start_ok), .wake_ok(wake_ok), .uvlo(uvlo), .latch_mode(latch_mode),
    .demand(demand), .drv_en(drv_en), .setpoint(setpoint), .state(state)
  );

  // switching-cycle stimulus: 4 clocks per cycle, limit pulse at cycle start
  initial begin
    int c = 0;
    int idx = 0;
    cyc_end = 1'b0;
    lim_hit = 1'b0;
    forever begin
      @(negedge clk);
      cyc_end = (c == 3);
      lim_hit = lim_en && (c == 0) &&
                !(skip_mod != 0 && (idx % skip_mod) == skip_mod - 1);
      if (c == 3) begin c = 0; idx++; end
      else c++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input int s, input int maxc, output int n);
    n = 0;
    while (state != 3'(s) && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_drv_off(input int maxc, output int n);
    n = 0;
    while (drv_en && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic bit ramp_ok(input int sp, input int d);
    for (int k = 0; k <= ST; k++) begin
      int r = (k * 255) / ST;
      if (((r < d) ? r : d) == sp) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic run_soft(input int d, output int dur);
    int prev = 0;
    dur = 0;
    while (state == 3'd1 && dur < 200) begin
      check(ramp_ok(int'(setpoint), d), "R3 ramp value", int'(setpoint), d);
      check(int'(setpoint) >= prev, "R3 ramp rising", int'(setpoint), prev);
      check(drv_en == 1'b1, "R3 drive on", int'(drv_en), 1);
      prev = int'(setpoint);
      @(negedge clk);
      dur++;
    end
  endtask

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int dur;
    rst_n = 1'b0; lim_en = 1'b0; skip_mod = 0;
    start_ok = 1'b0; wake_ok = 1'b0; uvlo = 1'b0; latch_mode = 1'b0;
    demand = 8'd200;
    step(3);
    check(state == 3'd0, "R1 reset state", int'(state), 0);
    check(drv_en == 1'b0, "R1 reset drive", int'(drv_en), 0);
    check(setpoint == 8'd0, "R1 reset setpoint", int'(setpoint), 0);
    rst_n = 1'b1;
    step(20);
    check(state == 3'd0, "R2 idle without start", int'(state), 0);

    start_ok = 1'b1;
    wait_state(1, 5, n);
    check(n <= 2, "R2 start latency", n, 1);
    run_soft(200, dur);
    check(dur >= (ST - 1) * P && dur <= ST * P + 3, "R3 soft duration", dur, ST * P);
    check(state == 3'd2, "R3 enters run", int'(state), 2);

    check(setpoint == 8'd200, "R4 run follows demand", int'(setpoint), 200);
    demand = 8'd37;
    step(1);
    check(setpoint == 8'd37, "R4 run follows new demand", int'(setpoint), 37);
    check(drv_en == 1'b1, "R4 drive on", int'(drv_en), 1);

    // broken overload: five limited cycles then one clean cycle
    skip_mod = 6; lim_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step(30);
      check(drv_en == 1'b1 && state == 3'd2, "R6 clean cycle clears timer", int'(state), 2);
    end
    lim_en = 1'b0; skip_mod = 0;
    step(8);

    // sustained overload in auto-recovery mode
    lim_en = 1'b1;
    wait_drv_off(500, n);
    check(n >= (FT - 1) * P && n <= FT * P + 8, "R5 timeout length", n, FT * P);
    check(state == 3'd3, "R7 discharge state", int'(state), 3);
    check(setpoint == 8'd0, "R7 setpoint zero", int'(setpoint), 0);
    step(40);
    check(state == 3'd3, "R7 start ignored in discharge", int'(state), 3);
    check(drv_en == 1'b0, "R7 drive off in discharge", int'(drv_en), 0);

    // hiccup restart with persisting fault
    wake_ok = 1'b1; step(1); wake_ok = 1'b0;
    wait_state(1, 6, n);
    check(state == 3'd1, "R8 restart enters soft-start", int'(state), 1);
    wait_drv_off(500, n);
    check(n >= (FT - 1) * P && n <= FT * P + 8, "R8 repeat timeout length", n, FT * P);
    check(state == 3'd3, "R8 repeated hiccup", int'(state), 3);

    // hiccup restart with fault cleared
    lim_en = 1'b0;
    wake_ok = 1'b1; step(1); wake_ok = 1'b0;
    wait_state(1, 6, n);
    check(state == 3'd1, "R8 soft-start on recovery", int'(state), 1);
    run_soft(37, dur);
    check(dur >= (ST - 1) * P && dur <= ST * P + 3, "R3 restart soft duration", dur, ST * P);
    check(state == 3'd2, "R8 resumes run", int'(state), 2);

    // latched mode
    latch_mode = 1'b1; lim_en = 1'b1;
    wait_drv_off(500, n);
    check(n >= (FT - 1) * P && n <= FT * P + 8, "R5 latched timeout length", n, FT * P);
    check(state == 3'd4, "R9 latched state", int'(state), 4);
    lim_en = 1'b0;
    wake_ok = 1'b1; step(1); wake_ok = 1'b0;
    step(30);
    check(state == 3'd4, "R9 wake and start ignored", int'(state), 4);
    check(drv_en == 1'b0, "R9 drive off", int'(drv_en), 0);

    start_ok = 1'b0;
    uvlo = 1'b1; step(1);
    check(state == 3'd0, "R10 uvlo leaves latch", int'(state), 0);
    uvlo = 1'b0; step(5);
    check(state == 3'd0, "R10 idle after uvlo", int'(state), 0);

    latch_mode = 1'b0; demand = 8'd120;
    start_ok = 1'b1;
    wait_state(2, 100, n);
    check(state == 3'd2, "R2 start to run", int'(state), 2);
    uvlo = 1'b1; step(1);
    check(state == 3'd0, "R10 uvlo from run", int'(state), 0);
    check(drv_en == 1'b0, "R10 drive off", int'(drv_en), 0);
    uvlo = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule